// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This unit steps through a multi-register load or store. A command carries a base address, a 16-bit mask of the registers taking part, and four control bits: one that picks whether the base is adjusted before or after a transfer, one for counting up or down, one that chooses load or store, and one that enables write-back of the base. Once the command is accepted, the unit puts out one word address per beat. Each beat also carries the index of the register to move and a write strobe. A beat stays on the outputs until the consumer takes it with a valid/ready handshake.

Whatever the direction, the lowest-numbered register always goes to the lowest address. For the descending forms the unit first works out the bottom of the block from the base and the number of set bits. It then walks upward in ascending register order. After the final beat the unit raises `done_o` for one cycle and shows the adjusted base, so the register file can write it back. A mask with no bits set finishes without any beats.

Top module: `bxs_seq`

## Requirements
- R1: After reset, `busy_o`, `beat_valid_o`, `done_o` and `wb_write_o` are all 0.
- R2: Ascending, adjust after (`pre_i`=0, `up_i`=1): the lowest listed register is at `base_i`, and each following listed register is 4 higher.
- R3: Ascending, adjust before (`pre_i`=1, `up_i`=1): the lowest listed register is at `base_i`+4, and each following listed register is 4 higher.
- R4: Descending, adjust after (`pre_i`=0, `up_i`=0): the highest listed register is at `base_i`, and the others sit 4 apart below it, so the lowest is at `base_i`-4·(n-1), where n is the number of set mask bits.
- R5: Descending, adjust before (`pre_i`=1, `up_i`=0): the highest listed register is at `base_i`-4, so the lowest is at `base_i`-4·n.
- R6: Beats come out in ascending register order. `beat_reg_o` is the bit position of each set mask bit, and `beat_addr_o` rises by 4 from one beat to the next.
- R7: `beat_write_o` is 1 for a store (`load_i`=0) and 0 for a load (`load_i`=1), on every beat.
- R8: A beat is taken only in a cycle where `beat_valid_o` and `beat_ready_i` are both 1. While `beat_ready_i` is 0, the address and register index stay unchanged.
- R9: `done_o` is 1 for exactly one cycle: the cycle after the handshake of the last beat. `beat_valid_o` is 0 in that cycle.
- R10: While `done_o` is 1, `wb_base_o` equals `base_i`+4·n when counting up, or `base_i`-4·n when counting down. `wb_write_o` equals the captured write-back enable while `done_o` is 1, and is 0 at all other times.
- R11: An empty mask produces no beat. `done_o` rises in the cycle after the start, and `wb_base_o` then equals `base_i`.
- R12: `start_i` is accepted only while `busy_o` is 0. Starts and input changes while busy have no effect on the sequence in progress.
- R13: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command strobe, taken when idle |
| base_i | input | 32 | Base address |
| list_i | input | 16 | Register mask |
| pre_i | input | 1 | 1: adjust base before the transfer, 0: after |
| up_i | input | 1 | 1: ascending block, 0: descending |
| load_i | input | 1 | 1: load, 0: store |
| wb_en_i | input | 1 | Write-back enable |
| busy_o | output | 1 | Command in progress |
| beat_valid_o | output | 1 | Beat on outputs |
| beat_ready_i | input | 1 | Consumer takes beat |
| beat_addr_o | output | 32 | Word address of beat |
| beat_reg_o | output | 4 | Register index of beat |
| beat_write_o | output | 1 | 1 for store beat |
| done_o | output | 1 | One-cycle completion pulse |
| wb_base_o | output | 32 | Adjusted base, valid with done |
| wb_write_o | output | 1 | Write-back request with done |

## Verification
Two situations are hard to reach from the ports. The first is a beat that is held off by ready while unrelated starts and new command fields arrive at the same moment. The second is a descending block whose lower end falls below address zero. The bench drives random back-pressure and random junk commands during every sequence. It also includes directed descending commands with small bases and ascending commands near the top of the address space. The results are checked against addresses computed independently in the bench.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic pre;
        logic up;
        logic load;
        logic wb_en;
    } xfer_mode_t;

    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/bxs_planner.sv
module bxs_planner
    import bxs_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 16
) (
    input  logic [AW-1:0]   base,
    input  logic [NREG-1:0] list,
    input  xfer_mode_t      mode,
    output logic [AW-1:0]   first_addr,
    output logic [AW-1:0]   wb_addr
);
    localparam int CW = $clog2(NREG + 1);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [CW-1:0] cnt;
    logic [AW-1:0] span;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt = cnt + CW'(list[i]);
        end
    end

    assign span = AW'(cnt) << 2;

    always_comb begin
        unique case ({mode.pre, mode.up})
            2'b01:   first_addr = base;
            2'b11:   first_addr = base + STEP;
            2'b00:   first_addr = base - span + STEP;
            default: first_addr = base - span;
        endcase
    end

    assign wb_addr = mode.up ? (base + span) : (base - span);

endmodule

// File: rtl/bxs_pick.sv
module bxs_pick #(
    parameter int NREG = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic [NREG-1:0] list,
    output logic [RW-1:0]   idx,
    output logic [NREG-1:0] rest,
    output logic            last
);
    logic [NREG-1:0] low;

    assign low  = list & (~list + NREG'(1));
    assign rest = list & ~low;
    assign last = (rest == '0);

    for (genvar b = 0; b < RW; b++) begin : g_enc
        logic [NREG-1:0] sel;
        for (genvar i = 0; i < NREG; i++) begin : g_sel
            assign sel[i] = low[i] & (((i >> b) & 1) == 1);
        end
        assign idx[b] = |sel;
    end

endmodule

// File: rtl/bxs_seq.sv
module bxs_seq
    import bxs_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [AW-1:0]   base_i,
    input  logic [NREG-1:0] list_i,
    input  logic            pre_i,
    input  logic            up_i,
    input  logic            load_i,
    input  logic            wb_en_i,
    output logic            busy_o,
    output logic            beat_valid_o,
    input  logic            beat_ready_i,
    output logic [AW-1:0]   beat_addr_o,
    output logic [RW-1:0]   beat_reg_o,
    output logic            beat_write_o,
    output logic            done_o,
    output logic [AW-1:0]   wb_base_o,
    output logic            wb_write_o
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    seq_state_e      state_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   wb_q;
    logic [NREG-1:0] left_q;
    logic            load_q;
    logic            wbe_q;

    xfer_mode_t      cmd_mode;
    logic [AW-1:0]   plan_first;
    logic [AW-1:0]   plan_wb;
    logic [NREG-1:0] pick_rest;
    logic            pick_last;
    logic            take;

    assign cmd_mode = '{pre: pre_i, up: up_i, load: load_i, wb_en: wb_en_i};

    bxs_planner #(.AW(AW), .NREG(NREG)) u_plan (
        .base       (base_i),
        .list       (list_i),
        .mode       (cmd_mode),
        .first_addr (plan_first),
        .wb_addr    (plan_wb)
    );

    bxs_pick #(.NREG(NREG)) u_pick (
        .list (left_q),
        .idx  (beat_reg_o),
        .rest (pick_rest),
        .last (pick_last)
    );

    assign take = (state_q == ST_RUN) && beat_ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wb_q    <= '0;
            left_q  <= '0;
            load_q  <= 1'b0;
            wbe_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    addr_q  <= plan_first;
                    wb_q    <= plan_wb;
                    left_q  <= list_i;
                    load_q  <= cmd_mode.load;
                    wbe_q   <= cmd_mode.wb_en;
                    state_q <= (|list_i) ? ST_RUN : ST_FIN;
                end
                ST_RUN: if (take) begin
                    left_q <= pick_rest;
                    addr_q <= addr_q + STEP;
                    if (pick_last) state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o       = (state_q != ST_IDLE);
    assign beat_valid_o = (state_q == ST_RUN);
    assign beat_addr_o  = addr_q;
    assign beat_write_o = ~load_q;
    assign done_o       = (state_q == ST_FIN);
    assign wb_base_o    = wb_q;
    assign wb_write_o   = done_o & wbe_q;

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!beat_valid_o && !done_o && !wb_write_o));

    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && beat_ready_i && !pick_last) |=> (beat_addr_o == $past(beat_addr_o) + STEP));

    a_r6_reg_rises: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && beat_ready_i && !pick_last) |=> (beat_reg_o > $past(beat_reg_o)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(beat_addr_o) && $stable(beat_reg_o)));

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && beat_ready_i && pick_last) |=> (done_o && !beat_valid_o));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r11_empty_done: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && list_i == '0) |=> (done_o && !beat_valid_o));

    a_r7_write_stable: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && !pick_last && beat_ready_i) |=> $stable(beat_write_o));

endmodule

// File: tb/bxs_seq_bench.sv
`timescale 1ns/1ps
module bxs_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] base_i;
    logic [15:0] list_i;
    logic        pre_i, up_i, load_i, wb_en_i;
    logic        busy_o, beat_valid_o, beat_ready_i;
    logic [31:0] beat_addr_o;
    logic [3:0]  beat_reg_o;
    logic        beat_write_o, done_o;
    logic [31:0] wb_base_o;
    logic        wb_write_o;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bxs_seq u_bxs_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .list_i(list_i),
        .pre_i(pre_i), .up_i(up_i), .load_i(load_i), .wb_en_i(wb_en_i),
        .busy_o(busy_o), .beat_valid_o(beat_valid_o), .beat_ready_i(beat_ready_i),
        .beat_addr_o(beat_addr_o), .beat_reg_o(beat_reg_o), .beat_write_o(beat_write_o),
        .done_o(done_o), .wb_base_o(wb_base_o), .wb_write_o(wb_write_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int bits_set(input logic [15:0] l);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(l[i]);
        return c;
    endfunction

    function automatic logic [31:0] low_addr(input logic [31:0] b, input logic [15:0] l, input logic p, input logic u);
        logic [31:0] s = 32'(bits_set(l)) * 32'd4;
        if (u) return p ? b + 32'd4 : b;
        return p ? b - s : b - s + 32'd4;
    endfunction

    function automatic logic [31:0] wb_val(input logic [31:0] b, input logic [15:0] l, input logic u);
        logic [31:0] s = 32'(bits_set(l)) * 32'd4;
        return u ? b + s : b - s;
    endfunction

    task automatic run_cmd(input logic [31:0] b, input logic [15:0] l, input logic p, input logic u,
                           input logic ld, input logic wb, input bit stall);
        logic [31:0] a;
        string mtag;
        mtag = u ? (p ? "R3" : "R2") : (p ? "R5" : "R4");
        chk(busy_o == 1'b0, "R12 idle before start", 32'(busy_o), 0);
        start_i = 1'b1; base_i = b; list_i = l; pre_i = p; up_i = u; load_i = ld; wb_en_i = wb;
        @(negedge clk);
        a = low_addr(b, l, p, u);
        for (int i = 0; i < 16; i++) begin
            if (l[i]) begin
                bit r;
                do begin
                    chk(beat_valid_o == 1'b1, "R8 beat valid", 32'(beat_valid_o), 1);
                    chk(beat_addr_o == a, {mtag, "/R13 beat address"}, beat_addr_o, a);
                    chk(beat_reg_o == 4'(i), "R6 register index", 32'(beat_reg_o), 32'(i));
                    chk(beat_write_o == ~ld, "R7 write strobe", 32'(beat_write_o), 32'(~ld));
                    chk(done_o == 1'b0, "R9 no early done", 32'(done_o), 0);
                    r = stall ? (($urandom % 3) != 0) : 1'b1;
                    beat_ready_i = r;
                    start_i = 1'($urandom); base_i = $urandom; list_i = 16'($urandom);
                    pre_i = 1'($urandom); up_i = 1'($urandom); load_i = 1'($urandom); wb_en_i = 1'($urandom);
                    @(negedge clk);
                end while (!r);
                a = a + 32'd4;
            end
        end
        beat_ready_i = 1'b0;
        start_i = 1'b0;
        chk(done_o == 1'b1, (l == 0) ? "R11 empty done" : "R9 done after last", 32'(done_o), 1);
        chk(beat_valid_o == 1'b0, "R9 no beat at done", 32'(beat_valid_o), 0);
        chk(wb_base_o == wb_val(b, l, u), (l == 0) ? "R11 base kept" : "R10 write-back base", wb_base_o, wb_val(b, l, u));
        chk(wb_write_o == wb, "R10 write-back enable", 32'(wb_write_o), 32'(wb));
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done one cycle", 32'(done_o), 0);
        chk(wb_write_o == 1'b0, "R10 no write-back outside done", 32'(wb_write_o), 0);
        chk(busy_o == 1'b0, "R12 idle after done", 32'(busy_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; start_i = 1'b0; base_i = '0; list_i = '0; pre_i = 0; up_i = 0;
        load_i = 0; wb_en_i = 0; beat_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy_o && !beat_valid_o && !done_o && !wb_write_o, "R1 reset state",
            {28'd0, busy_o, beat_valid_o, done_o, wb_write_o}, 0);
        run_cmd(32'h0000_1000, 16'h80F1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        run_cmd(32'h0000_1000, 16'h80F1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        run_cmd(32'h0000_1000, 16'h80F1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run_cmd(32'h0000_1000, 16'h80F1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        run_cmd(32'h0000_2000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        run_cmd(32'h0000_3000, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        run_cmd(32'h0000_4000, 16'h8000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        run_cmd(32'h0000_0008, 16'h0F0F, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        run_cmd(32'hFFFF_FFF8, 16'h00FF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 80; k++) begin
            logic [15:0] l;
            l = 16'($urandom) & 16'($urandom | $urandom);
            if (k % 9 == 0) l = '0;
            run_cmd({$urandom} & 32'hFFFF_FFFC, l, 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 1'b1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule